// File: doc/BRIEF.md
# Excessive CRC Error Second Monitor

This block watches a stream of single-cycle pulses, each raised when a received frame's CRC check word differs from the one computed locally, and counts them inside fixed one-second windows. A one-cycle tick, generated elsewhere, marks where each window ends and the next begins. When the count in the current window reaches a threshold, the block emits a single-cycle event pulse, meant to set a sticky status bit further along the chain.

The threshold defaults to 320 in the extended-superframe DS1 mode and to 915 in the E1 CRC-4 mode. Software may replace either default with its own value. Counting only takes place while the line runs in one of these two CRC-capable modes. The enable input says so, and the surrounding framer drives it.

Top module: `crc_xs_sec_mon`

## Requirements
- R1: After reset, `xs_event` is low and the window count is zero. The first window then needs a full threshold of errors before it can fire.
- R2: When `thr_ovr_en`=0 and `mode_cept`=0, the threshold is 320 errors: 319 errors in a window produce no event, and the 320th does.
- R3: When `thr_ovr_en`=0 and `mode_cept`=1, the threshold is 915 errors: 914 errors produce no event, and the 915th does.
- R4: When `thr_ovr_en`=1, the threshold is `thr_ovr`, whatever the mode. A value of 0 behaves as 1.
- R5: `xs_event` is high for exactly the one cycle that follows the rising clock edge that samples the error bringing the count to the threshold.
- R6: `xs_event` fires at most once per window, however many errors follow in that window.
- R7: `sec_tick` restarts the count at zero and re-arms the event. An error sampled in the same cycle as the tick is the first error of the new window.
- R8: While `crc_mode_en`=0, errors are ignored, the count is held at zero, and `xs_event` stays low. After re-enabling, a full threshold is needed.
- R9: The count saturates at 2^CNT_W-1 and never wraps, so a threshold of 2^CNT_W-1 is still reached exactly once.
- R10: An event is only produced on a counted error. Lowering the threshold below the current count does not fire until the next error arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_err | input | 1 | One-cycle pulse per CRC-mismatched frame |
| sec_tick | input | 1 | One-cycle pulse marking each one-second boundary |
| mode_cept | input | 1 | 0 selects the DS1 extended-superframe default, 1 selects the E1 CRC-4 default |
| crc_mode_en | input | 1 | High when the line is in a CRC-capable mode |
| thr_ovr_en | input | 1 | Selects the software threshold |
| thr_ovr | input | CNT_W | Software threshold value |
| xs_event | output | 1 | One-cycle excessive-CRC event |

## Verification
A window boundary and an error can arrive in the same cycle. Restarting the count and counting the error then have to combine into a count of one, not zero and not a carry-over. The bench drives an error together with the tick after a partly filled window. It then checks that exactly threshold-1 further errors are needed, and that a window split across a tick never adds up both halves. A tick can also land in the cycle right after an event with an error on it, and the bench checks that an event with a threshold of one can fire back to back across that boundary.

// File: rtl/crc_xs_sec_mon.sv
module crc_xs_sec_mon #(
  parameter int CNT_W    = 10,
  parameter int ESF_THR  = 320,
  parameter int CEPT_THR = 915
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_err,
  input  logic             sec_tick,
  input  logic             mode_cept,
  input  logic             crc_mode_en,
  input  logic             thr_ovr_en,
  input  logic [CNT_W-1:0] thr_ovr,
  output logic             xs_event
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ESF_T   = CNT_W'(ESF_THR);
  localparam logic [CNT_W-1:0] CEPT_T  = CNT_W'(CEPT_THR);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cnt_base, cnt_nx, thr_sel, thr_eff;
  logic             fired, fired_base, err_q, hit;

  assign err_q      = crc_err & crc_mode_en;
  assign cnt_base   = sec_tick ? '0 : cnt;
  assign fired_base = sec_tick ? 1'b0 : fired;
  assign cnt_nx     = (err_q && cnt_base != CNT_MAX) ? cnt_base + ONE : cnt_base;
  assign thr_sel    = thr_ovr_en ? thr_ovr : (mode_cept ? CEPT_T : ESF_T);
  assign thr_eff    = (thr_sel == '0) ? ONE : thr_sel;
  assign hit        = err_q && !fired_base && (cnt_nx >= thr_eff);

  always_ff @(posedge clk) begin
    if (!rst_n || !crc_mode_en) begin
      cnt      <= '0;
      fired    <= 1'b0;
      xs_event <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      fired    <= fired_base | hit;
      xs_event <= hit;
    end
  end
endmodule

// File: rtl/crc_xs_sec_mon_chk.sv
module crc_xs_sec_mon_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             crc_err,
  input logic             sec_tick,
  input logic             crc_mode_en,
  input logic [CNT_W-1:0] cnt,
  input logic             xs_event
);
  AST_ONE_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (xs_event && !sec_tick) |=> !xs_event); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_mode_en |=> (!xs_event && cnt == '0)); // R8
  AST_EVENT_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_err |=> !xs_event); // R10
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !crc_err) |=> cnt == '0); // R7
  AST_TICK_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && crc_err && crc_mode_en) |=> cnt == CNT_W'(1)); // R7
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {CNT_W{1'b1}} && crc_mode_en && !sec_tick) |=> cnt == {CNT_W{1'b1}}); // R9
endmodule

bind crc_xs_sec_mon crc_xs_sec_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .crc_err(crc_err), .sec_tick(sec_tick),
  .crc_mode_en(crc_mode_en), .cnt(cnt), .xs_event(xs_event)
);

// File: tb/crc_xs_sec_mon_bench.sv
`timescale 1ns/1ps
module crc_xs_sec_mon_bench;
  localparam int W = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic crc_err = 0, sec_tick = 0, mode_cept = 0, crc_mode_en = 1, thr_ovr_en = 0;
  logic [W-1:0] thr_ovr = '0;
  logic xs_event;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  crc_xs_sec_mon #(.CNT_W(W)) u_crc_xs_sec_mon (
    .clk(clk), .rst_n(rst_n), .crc_err(crc_err), .sec_tick(sec_tick),
    .mode_cept(mode_cept), .crc_mode_en(crc_mode_en), .thr_ovr_en(thr_ovr_en),
    .thr_ovr(thr_ovr), .xs_event(xs_event));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample just after the capturing edge
  task automatic step(input logic e, input logic t, output logic ev);
    @(negedge clk);
    crc_err = e; sec_tick = t;
    @(posedge clk); #1;
    ev = xs_event;
    @(negedge clk);
    crc_err = 0; sec_tick = 0;
  endtask

  // n errors back to back; reports 1-based index of first event and event total
  task automatic burst(input int n, output int first, output int total);
    logic ev;
    first = 0; total = 0;
    for (int i = 1; i <= n; i++) begin
      step(1'b1, 1'b0, ev);
      if (ev) begin total++; if (first == 0) first = i; end
    end
  endtask

  task automatic tick_only();
    logic ev;
    step(1'b0, 1'b1, ev);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 event low in reset", xs_event, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_esf();
    int f, t;
    mode_cept = 0; thr_ovr_en = 0; tick_only();
    burst(319, f, t); check("R2 no event at 319", t, 0);
    burst(1, f, t);   check("R2 event on 320th", t, 1);
    burst(50, f, t);  check("R6 no repeat in window", t, 0);
  endtask

  task automatic t_cept();
    int f, t;
    mode_cept = 1; thr_ovr_en = 0; tick_only();
    burst(920, f, t);
    check("R3 event index 915", f, 915);
    check("R6 single event", t, 1);
  endtask

  task automatic t_pulse_width();
    int f, t; logic ev, ev2;
    thr_ovr_en = 1; thr_ovr = 3; tick_only();
    burst(2, f, t); check("R5 none before threshold", t, 0);
    step(1'b1, 1'b0, ev); check("R5 event after capturing edge", ev, 1);
    step(1'b0, 1'b0, ev2); check("R5 one cycle wide", ev2, 0);
  endtask

  task automatic t_override();
    int f, t;
    mode_cept = 1; thr_ovr_en = 1; thr_ovr = 7; tick_only();
    burst(10, f, t); check("R4 override index", f, 7);
    thr_ovr = 0; tick_only();
    burst(3, f, t); check("R4 zero acts as one", f, 1);
    check("R4 zero single event", t, 1);
  endtask

  task automatic t_tick_coincide();
    int f, t; logic ev;
    thr_ovr_en = 1; thr_ovr = 5; tick_only();
    burst(4, f, t);
    step(1'b1, 1'b1, ev); check("R7 tick+err no carry-over", ev, 0);
    burst(3, f, t); check("R7 count 4 in new window", t, 0);
    burst(1, f, t); check("R7 event at 5th incl tick err", t, 1);
    tick_only(); burst(3, f, t); tick_only(); burst(3, f, t);
    check("R7 split window does not sum", t, 0);
    thr_ovr = 1; tick_only();
    burst(1, f, t); check("R7 thr1 first", t, 1);
    step(1'b1, 1'b1, ev); check("R7 rearm on tick back to back", ev, 1);
  endtask

  task automatic t_disable();
    int f, t;
    thr_ovr_en = 1; thr_ovr = 4; tick_only();
    burst(3, f, t);
    crc_mode_en = 0;
    burst(10, f, t); check("R8 no event while disabled", t, 0);
    crc_mode_en = 1;
    burst(3, f, t); check("R8 count cleared by disable", t, 0);
    burst(1, f, t); check("R8 full threshold after enable", t, 1);
  endtask

  task automatic t_lower_thr();
    int f, t; logic ev;
    thr_ovr_en = 1; thr_ovr = 10; tick_only();
    burst(6, f, t);
    thr_ovr = 3;
    repeat (4) begin step(1'b0, 1'b0, ev); check("R10 no event without error", ev, 0); end
    burst(1, f, t); check("R10 fires on next error", t, 1);
  endtask

  task automatic t_saturate();
    int f, t;
    thr_ovr_en = 1; thr_ovr = '1; tick_only();
    burst(1040, f, t);
    check("R9 max threshold index", f, 1023);
    check("R9 single event past max", t, 1);
  endtask

  initial begin
    t_reset();
    t_esf();
    t_cept();
    t_pulse_width();
    t_override();
    t_tick_coincide();
    t_disable();
    t_lower_thr();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule